// File: doc/BRIEF.md
# Command Packet Register-Write Engine

This block sits at the receiving end of a command stream. It takes packets on a 64-bit AXI4-Stream input and turns each command packet into one write on a simple register bus. The register bus has an 8-bit address, 32-bit data and a strobe that lasts a single cycle. The first beat of every packet is a header. The header gives the packet kind and a flag that marks the command as timed. It also carries a sequence number, a byte length and two stream identifiers, and this block does not act on any of those four.

An untimed command has two beats: the header, then the word that carries the register address and value. A timed command has a 64-bit time beat between those two. The engine keeps its own 64-bit time counter and holds a timed write back until that counter has reached the command time. While the write is held, the engine stalls the input stream. Packets of any other kind are drained to their last beat without a write. After the payload of a command, any further beats up to tlast are discarded.

Top module: `cmd_write_engine`

## Requirements
- R1: After reset, wr_stb is low and s_tready is high, and the local time counter starts from 0. The counter then increases by one on every clock edge while out of reset.
- R2: An untimed command is a header beat followed by a payload beat. It produces exactly one write. The strobe is high in the cycle right after the edge that accepted the payload, with wr_addr = payload[39:32] and wr_data = payload[31:0]. Payload bits [63:40] are zero.
- R3: The header kind is in bits [63:62] and the value 2'b10 means command. The has-time flag is bit 61. Bit 60 is end-of-burst, [59:48] the sequence number, [47:32] the length, [31:16] the source ID and [15:0] the destination ID.
- R4: When has-time is set, the beat after the header is a 64-bit time T. The write is not issued before the counter reaches T. If the payload arrives earlier, the strobe is high in the cycle in which the counter reads T+1.
- R5: While a timed write is being held, s_tready stays low and no beat is accepted.
- R6: If the time T of a timed command has already passed when its payload is accepted, the write comes out one cycle after the payload, just as for an untimed command.
- R7: A packet whose kind is not 2'b10 is consumed up to tlast without any write. s_tready stays high throughout.
- R8: Beats after the payload of a command, up to tlast, are discarded. They cause no further write and do not change wr_addr or wr_data.
- R9: The sequence number, end-of-burst bit, length and stream IDs have no effect. A sequence number of zero, or one that repeats, is still executed.
- R10: wr_stb is never high for two cycles in a row.
- R11: A command packet that ends with tlast before its payload beat produces no write. The next packet is then parsed from its header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 64 | Stream data |
| s_tvalid | input | 1 | Stream valid |
| s_tlast | input | 1 | Last beat of packet |
| s_tready | output | 1 | Stream ready; low while a timed write waits |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 32 | Register value of the write |
| wr_stb | output | 1 | One-cycle write strobe |

## Verification
Some rules are checked by the assertions on every cycle:
- The strobe never lasts two cycles.
- A strobe only follows the payload or hold state, so no write can come out of a drained packet, an extra beat or a header that is cut short.
- A timed strobe never appears while the counter is still at or below the command time.
- No beat is taken while a write is held.

Other behaviour can only be shown by the directed scenarios:
- The exact decoding of the header kind and time flag.
- The address and value taken from the payload.
- The exact cycle at which a held write is released.
- The fact that the ignored header fields and repeated sequence numbers change nothing.

// File: rtl/cmd_write_pkg.sv
// Shared definitions for the command register-write engine.
// Holds the parser states and the bit positions of the header fields
// that the parser acts on. It assumes the stream is 64 bits wide.
package cmd_write_pkg;

    localparam int          BEAT_W       = 64;
    localparam int          KIND_HI      = 63;
    localparam int          KIND_LO      = 62;
    localparam int          TIMED_BIT    = 61;
    localparam logic [1:0]  KIND_COMMAND = 2'b10;

    typedef enum logic [2:0] {
        ST_HDR   = 3'd0,
        ST_TIME  = 3'd1,
        ST_PAY   = 3'd2,
        ST_HOLD  = 3'd3,
        ST_DRAIN = 3'd4
    } parse_st_t;

endpackage

// File: rtl/cmd_time_base.sv
// Local time counter for the command engine.
// It clears to zero in reset and then counts up by one every clock.
// It assumes the counter is wide enough never to wrap in practice.
module cmd_time_base #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now
);

    // Free-running count, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

endmodule

// File: rtl/cmd_parse_fsm.sv
// Packet parser and write issuer.
// It walks each packet through header, optional time, payload and drain.
// A timed command is held in ST_HOLD, with the input stalled, until the
// local time reaches the command time. The write then comes out from
// registers. It assumes the header layout given in cmd_write_pkg.
module cmd_parse_fsm
    import cmd_write_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int VAL_W  = 32,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEAT_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    input  logic [TIME_W-1:0] now,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [VAL_W-1:0]  wr_data,
    output logic              wr_stb,
    output logic              held
);

    localparam int ADDR_LO = VAL_W;
    localparam int ADDR_HI = VAL_W + ADDR_W - 1;

    parse_st_t          st;
    logic               timed_q;
    logic               end_q;
    logic [TIME_W-1:0]  cmd_time_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [VAL_W-1:0]   data_q;
    logic               stb_q;
    logic               beat;
    logic               is_cmd;

    // Stall the stream only while a timed write waits.
    always_comb begin
        s_tready = (st != ST_HOLD);
        held     = (st == ST_HOLD);
        beat     = s_tvalid && s_tready;
        is_cmd   = (s_tdata[KIND_HI:KIND_LO] == KIND_COMMAND);
    end

    // Parser state, captured fields and the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_HDR;
            timed_q    <= 1'b0;
            end_q      <= 1'b0;
            cmd_time_q <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            stb_q      <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            case (st)
                ST_HDR: if (beat) begin
                    if (is_cmd) begin
                        timed_q <= s_tdata[TIMED_BIT];
                        if (s_tlast)                 st <= ST_HDR;
                        else if (s_tdata[TIMED_BIT]) st <= ST_TIME;
                        else                         st <= ST_PAY;
                    end else if (!s_tlast) begin
                        st <= ST_DRAIN;
                    end
                end
                ST_TIME: if (beat) begin
                    cmd_time_q <= s_tdata[TIME_W-1:0];
                    st         <= s_tlast ? ST_HDR : ST_PAY;
                end
                ST_PAY: if (beat) begin
                    addr_q <= s_tdata[ADDR_HI:ADDR_LO];
                    data_q <= s_tdata[VAL_W-1:0];
                    end_q  <= s_tlast;
                    if (timed_q && (now < cmd_time_q)) begin
                        st <= ST_HOLD;
                    end else begin
                        stb_q <= 1'b1;
                        st    <= s_tlast ? ST_HDR : ST_DRAIN;
                    end
                end
                ST_HOLD: if (now >= cmd_time_q) begin
                    stb_q <= 1'b1;
                    st    <= end_q ? ST_HDR : ST_DRAIN;
                end
                ST_DRAIN: if (beat && s_tlast) st <= ST_HDR;
                default: st <= ST_HDR;
            endcase
        end
    end

    assign wr_addr = addr_q;
    assign wr_data = data_q;
    assign wr_stb  = stb_q;

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R10
    AST_STB_FROM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(st) == ST_PAY || $past(st) == ST_HOLD)); // R7
    AST_TIMED_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && timed_q) |-> (now > cmd_time_q)); // R4

endmodule

// File: rtl/cmd_write_engine.sv
// Top of the command register-write engine.
// It joins the local time base to the packet parser. It assumes a single
// clock domain and that the downstream register bus takes every strobe.
module cmd_write_engine #(
    parameter int ADDR_W = 8,
    parameter int VAL_W  = 32,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [VAL_W-1:0]  wr_data,
    output logic              wr_stb
);

    logic [TIME_W-1:0] now;
    logic              held;

    cmd_time_base #(.TIME_W(TIME_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    cmd_parse_fsm #(.ADDR_W(ADDR_W), .VAL_W(VAL_W), .TIME_W(TIME_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_tdata  (s_tdata),
        .s_tvalid (s_tvalid),
        .s_tlast  (s_tlast),
        .s_tready (s_tready),
        .now      (now),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_stb   (wr_stb),
        .held     (held)
    );

    AST_NO_ACCEPT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !(s_tvalid && s_tready)); // R5

endmodule

// File: tb/cmd_write_engine_bench.sv
module cmd_write_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        wr_stb;

    int          checks = 0;
    int          fails = 0;
    int          nw = 0;
    int          wide_err = 0;
    logic        prev_stb = 1'b0;
    logic [7:0]  la = '0;
    logic [31:0] ld = '0;
    logic [63:0] lnow = '0;
    logic [63:0] bt = '0;
    logic [63:0] acc_bt = '0;

    always #5 clk = ~clk;

    cmd_write_engine u_cmd_write_engine (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .s_tready(s_tready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_stb(wr_stb)
    );

    // Bench view of local time as defined in R1
    always @(posedge clk) begin
        if (!rst_n) bt <= '0;
        else        bt <= bt + 1;
    end

    // Write monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                nw++; la = wr_addr; ld = wr_data; lnow = bt;
                if (prev_stb) wide_err++;
            end
            prev_stb = wr_stb;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] hdr(input logic [1:0] kind, input logic tm, input logic eob,
                                        input logic [11:0] seq);
        return {kind, tm, eob, seq, 16'd16, 16'h0123, 16'h4567};
    endfunction

    function automatic logic [63:0] pay(input logic [7:0] a, input logic [31:0] d);
        return {24'd0, a, d};
    endfunction

    task automatic send_beat(input logic [63:0] d, input logic l);
        @(negedge clk);
        s_tdata = d; s_tlast = l; s_tvalid = 1'b1;
        while (!s_tready) @(negedge clk);
        @(posedge clk); #1;
        s_tvalid = 1'b0; s_tlast = 1'b0;
        acc_bt = bt;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(wr_stb == 1'b0, "R1 stb low after reset", wr_stb, 0);
        chk(s_tready == 1'b1, "R1 ready high after reset", s_tready, 1);
    endtask

    task automatic t_untimed();
        int n0 = nw;
        send_beat(hdr(2'b10, 1'b0, 1'b0, 12'd1), 1'b0);
        send_beat(pay(8'h5A, 32'hDEADBEEF), 1'b1);
        idle(3);
        chk(nw == n0 + 1, "R2 one write", nw, n0 + 1);
        chk(la == 8'h5A, "R2 address", la, 8'h5A);
        chk(ld == 32'hDEADBEEF, "R2 data", ld, 32'hDEADBEEF);
        chk(lnow == acc_bt, "R2 strobe cycle", lnow, acc_bt);
    endtask

    task automatic t_timed_future();
        int n0 = nw;
        logic [63:0] t;
        send_beat(hdr(2'b10, 1'b1, 1'b0, 12'd2), 1'b0);
        t = bt + 40;
        send_beat(t, 1'b0);
        send_beat(pay(8'h11, 32'h0000CAFE), 1'b1);
        @(negedge clk);
        chk(s_tready == 1'b0, "R5 ready low while held", s_tready, 0);
        chk(nw == n0, "R4 no early write", nw, n0);
        for (int i = 0; i < 100 && nw == n0; i++) @(negedge clk);
        chk(nw == n0 + 1, "R4 write released", nw, n0 + 1);
        chk(lnow == t + 1, "R4 release cycle R3 time flag", lnow, t + 1);
        chk(ld == 32'h0000CAFE, "R4 data", ld, 32'h0000CAFE);
        @(negedge clk);
        chk(s_tready == 1'b1, "R5 ready back high", s_tready, 1);
    endtask

    task automatic t_timed_past();
        int n0 = nw;
        send_beat(hdr(2'b10, 1'b1, 1'b1, 12'd3), 1'b0);
        send_beat(64'd5, 1'b0);
        send_beat(pay(8'h22, 32'h12345678), 1'b1);
        idle(3);
        chk(nw == n0 + 1 && lnow == acc_bt, "R6 past time immediate", lnow, acc_bt);
    endtask

    task automatic t_other_kind();
        int n0 = nw;
        bit rdy = 1'b1;
        send_beat(hdr(2'b00, 1'b0, 1'b0, 12'd4), 1'b0);
        rdy &= s_tready;
        send_beat(pay(8'h33, 32'h1), 1'b0);
        rdy &= s_tready;
        send_beat(pay(8'h34, 32'h2), 1'b1);
        idle(3);
        chk(nw == n0, "R7 no write for kind 00", nw, n0);
        chk(rdy, "R7 ready stays high", rdy, 1);
        send_beat(hdr(2'b11, 1'b0, 1'b0, 12'd5), 1'b0);
        send_beat(pay(8'h35, 32'h3), 1'b1);
        idle(3);
        chk(nw == n0, "R3 kind 11 is not a command", nw, n0);
        chk(la == 8'h22, "R7 address unchanged", la, 8'h22);
    endtask

    task automatic t_extra_beats();
        int n0 = nw;
        send_beat(hdr(2'b10, 1'b0, 1'b0, 12'd6), 1'b0);
        send_beat(pay(8'h44, 32'hA5A5A5A5), 1'b0);
        send_beat(pay(8'h55, 32'h0), 1'b0);
        send_beat(pay(8'h66, 32'h1), 1'b1);
        idle(3);
        chk(nw == n0 + 1, "R8 one write only", nw, n0 + 1);
        chk(wr_addr == 8'h44 && wr_data == 32'hA5A5A5A5, "R8 fields kept", wr_addr, 8'h44);
    endtask

    task automatic t_seq();
        int n0 = nw;
        send_beat(hdr(2'b10, 1'b0, 1'b0, 12'd0), 1'b0);
        send_beat(pay(8'h70, 32'h70), 1'b1);
        send_beat(hdr(2'b10, 1'b0, 1'b1, 12'd7), 1'b0);
        send_beat(pay(8'h71, 32'h71), 1'b1);
        send_beat(hdr(2'b10, 1'b0, 1'b0, 12'd7), 1'b0);
        send_beat(pay(8'h72, 32'h72), 1'b1);
        idle(3);
        chk(nw == n0 + 3, "R9 seq zero and repeats executed", nw, n0 + 3);
        chk(la == 8'h72, "R9 last address", la, 8'h72);
    endtask

    task automatic t_short();
        int n0 = nw;
        send_beat(hdr(2'b10, 1'b0, 1'b0, 12'd8), 1'b1);
        send_beat(hdr(2'b10, 1'b1, 1'b0, 12'd9), 1'b0);
        send_beat(64'd0, 1'b1);
        idle(3);
        chk(nw == n0, "R11 short packets no write", nw, n0);
        send_beat(hdr(2'b10, 1'b0, 1'b0, 12'd10), 1'b0);
        send_beat(pay(8'h80, 32'h80), 1'b1);
        idle(3);
        chk(nw == n0 + 1 && la == 8'h80, "R11 next packet parsed", la, 8'h80);
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_untimed();
        t_timed_future();
        t_timed_past();
        t_other_kind();
        t_extra_beats();
        t_seq();
        t_short();
        chk(wide_err == 0, "R10 strobe single cycle", wide_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule